// File: doc/BRIEF.md
# Memory Consistency Self-Test Sequencer

This block sequences the periodic consistency check of an embedded word-organised memory whose known-good contents are summarised by a self-adjusting characteristic. The characteristic is the XOR of the addresses of every stored 1. Each address has two parts: the word address and the bit index inside the word. The block owns no data. It emits the strobes that steer an external compressor, a reference register, a test register and a comparator, and it drives the scan address counter and the select of the memory address multiplexer.

It has three activities. A learn pass clears the compressor, sweeps every word address and loads the final sum into the reference register. A system write runs as a two-cycle sequence. The first cycle moves the old word into the test register. The second cycle writes the new word and folds (old XOR new) at the written address into the compressor, and the reference register captures the updated sum on that same edge. The reference register always captures the compressor's next value. A self-test pass repeats the sweep with the reference load held off and then enables the comparator for one cycle.

Write requests use a valid/ready handshake. A request is taken on an edge where `wr_valid` and `wr_ready` are both high. The requester must hold the system address and data from that edge through the two cycles that follow. While `wr_ready` is low, the requester keeps `wr_valid` high and waits. Reads do not involve this block.

Top module: `memchk_ctrl`

## Requirements
- R1: After reset the block is idle. All strobes, `busy` and `addr_sel` are 0, `gen_addr` is 0, and `wr_ready` is 1 while no scan request is present.
- R2: A scan starts in the cycle after it is requested. The first cycle asserts `comp_clr`. Then come DEPTH cycles with `comp_en`=1 and `gen_addr` stepping 0,1,…,DEPTH-1. `addr_sel`=1 (generator address selected) throughout. `gen_addr` is 0 whenever no sweep cycle is in progress.
- R3: In a learn pass, `ref_en` is 1 only in the final sweep cycle (`gen_addr`=DEPTH-1), and the reference then equals the characteristic of the whole memory.
- R4: In a self-test pass, `ref_en` stays 0 for the whole sweep. Exactly one cycle with `cmp_en`=1 and `addr_sel`=0 follows the last sweep cycle, and then the block is idle. An unchanged memory compares equal. A single flipped bit yields a difference of {word address, bit index}.
- R5: `wr_ready` is 1 only when the block is idle and neither `init_req` nor `run_bist` is high.
- R6: In the first cycle after a write is accepted, only `old_xfer` is asserted among the strobes, with `addr_sel`=0.
- R7: In the second cycle, `mem_we`, `comp_en` and `ref_en` are 1. The block is idle in the cycle after that, so a held `wr_valid` is accepted every third cycle.
- R8: `busy` is 1 in the clear, sweep and compare cycles, and `wr_ready` is 0 during them.
- R9: When several requests are seen in the same idle cycle, `init_req` takes priority over `run_bist`, and `run_bist` takes priority over a write. A write that loses stays pending and is accepted after the scan.
- R10: With learn, any mix of writes and a later self-test, the reference tracks the memory characteristic and the self-test compares equal.
- R11: `init_req` and `run_bist` are ignored outside the idle state. The running sequence is unchanged and no new scan starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Request a learn pass |
| run_bist | input | 1 | Request a self-test pass |
| wr_valid | input | 1 | System write request (valid) |
| wr_ready | output | 1 | Write request accepted when high with valid |
| busy | output | 1 | Scan in progress; writes stalled |
| gen_addr | output | ADDR_W | Scan address generator value |
| addr_sel | output | 1 | 1 selects the generator address, 0 the system address |
| comp_clr | output | 1 | Clear compressor to zero |
| comp_en | output | 1 | Compressor accumulates its current input |
| ref_en | output | 1 | Reference register loads the compressor's next value |
| old_xfer | output | 1 | Move the old word into the test register |
| mem_we | output | 1 | Write the new word into memory |
| cmp_en | output | 1 | Comparator produces pass/fail |

## Verification
A scan request and a write request can fall in the same idle cycle. So can a scan request and a write sequence that is already in flight. The bench raises `init_req` together with a held `wr_valid`, raises `init_req` and `run_bist` together, and pulses scan requests during sweeps and write cycles. A behavioural model compares every strobe on every clock. A bench-side memory and compressor then judge the outcome: the reference must still match the memory and later self-tests must compare equal, while an injected bit flip must report its own address.

// File: rtl/memchk_pkg.sv
`timescale 1ns/1ps
package memchk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WCAP = 3'd1,
    ST_WUPD = 3'd2,
    ST_CLR  = 3'd3,
    ST_SCAN = 3'd4,
    ST_CMP  = 3'd5
  } seq_state_t;
endpackage

// File: rtl/memchk_addr_gen.sv
`timescale 1ns/1ps
module memchk_addr_gen #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr || (adv && last)) cnt_q <= '0;
    else if (adv)                cnt_q <= cnt_q + 1'b1;
  end

  assign addr = cnt_q;
  assign last = (cnt_q == LAST_A);

  // wrap returns to zero after the final address
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last) |=> (cnt_q == '0));
endmodule

// File: rtl/memchk_seq.sv
`timescale 1ns/1ps
module memchk_seq
  import memchk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       run_bist,
  input  logic       wr_valid,
  input  logic       scan_last,
  output seq_state_t state,
  output logic       test_mode
);
  seq_state_t st_q, st_d;
  logic       test_q, test_d;

  always_comb begin
    st_d   = st_q;
    test_d = test_q;
    unique case (st_q)
      ST_IDLE: begin
        if (init_req) begin
          st_d   = ST_CLR;
          test_d = 1'b0;
        end else if (run_bist) begin
          st_d   = ST_CLR;
          test_d = 1'b1;
        end else if (wr_valid) begin
          st_d = ST_WCAP;
        end
      end
      ST_WCAP: st_d = ST_WUPD;
      ST_WUPD: st_d = ST_IDLE;
      ST_CLR:  st_d = ST_SCAN;
      ST_SCAN: if (scan_last) st_d = test_q ? ST_CMP : ST_IDLE;
      ST_CMP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      test_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      test_q <= test_d;
    end
  end

  assign state     = st_q;
  assign test_mode = test_q;

  // learn request wins over self-test and write in the same idle cycle
  assert_init_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && init_req) |=> (st_q == ST_CLR && !test_q));
  // requests outside idle leave the running sequence alone
  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SCAN && !scan_last) |=> (st_q == ST_SCAN && $stable(test_q)));
endmodule

// File: rtl/memchk_ctrl.sv
`timescale 1ns/1ps
module memchk_ctrl
  import memchk_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_req,
  input  logic              run_bist,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic              busy,
  output logic [ADDR_W-1:0] gen_addr,
  output logic              addr_sel,
  output logic              comp_clr,
  output logic              comp_en,
  output logic              ref_en,
  output logic              old_xfer,
  output logic              mem_we,
  output logic              cmp_en
);
  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(DEPTH - 1);

  seq_state_t state;
  logic       test_mode;
  logic       scan_last;
  logic       in_scan;

  assign in_scan = (state == ST_SCAN);

  memchk_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_req  (init_req),
    .run_bist  (run_bist),
    .wr_valid  (wr_valid),
    .scan_last (scan_last),
    .state     (state),
    .test_mode (test_mode)
  );

  memchk_addr_gen #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_agen (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == ST_CLR),
    .adv   (in_scan),
    .addr  (gen_addr),
    .last  (scan_last)
  );

  always_comb begin
    busy     = (state == ST_CLR) || in_scan || (state == ST_CMP);
    addr_sel = (state == ST_CLR) || in_scan;
    comp_clr = (state == ST_CLR);
    comp_en  = in_scan || (state == ST_WUPD);
    ref_en   = (in_scan && scan_last && !test_mode) || (state == ST_WUPD);
    old_xfer = (state == ST_WCAP);
    mem_we   = (state == ST_WUPD);
    cmp_en   = (state == ST_CMP);
    wr_ready = (state == ST_IDLE) && !init_req && !run_bist;
  end

  // clear is followed by the first sweep address
  assert_clr_then_sweep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    comp_clr |=> (comp_en && addr_sel && gen_addr == '0));
  // reference load only ever accompanies an accumulation
  assert_ref_with_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_en |-> comp_en);
  // compare follows the final sweep address of a pass with no reference load
  assert_cmp_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> ($past(comp_en) && $past(gen_addr) == LAST_A && !$past(ref_en)));
  // handshake only taken while nothing else is running
  assert_ready_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!busy && !old_xfer && !mem_we));
  // capture cycle is followed by the update cycle
  assert_xfer_then_upd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    old_xfer |=> (mem_we && comp_en && ref_en && !addr_sel));
  // update never occurs without the capture cycle before it
  assert_upd_after_xfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(old_xfer));
  // stall while scanning
  assert_busy_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);
  // single-purpose strobes never overlap
  assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({comp_clr, old_xfer, mem_we, cmp_en}));
endmodule

// File: tb/memchk_ctrl_tb.sv
`timescale 1ns/1ps
module memchk_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int W     = 8;
  localparam int BW    = $clog2(W);
  localparam int CW    = AW + BW;
  localparam int M_IDLE = 0, M_WCAP = 1, M_WUPD = 2, M_CLR = 3, M_SCAN = 4, M_CMP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req = 1'b0, run_bist = 1'b0, wr_valid = 1'b0;
  logic wr_ready, busy, addr_sel, comp_clr, comp_en, ref_en, old_xfer, mem_we, cmp_en;
  logic [AW-1:0] gen_addr;

  always #2.5 clk = ~clk;

  memchk_ctrl #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .init_req(init_req), .run_bist(run_bist),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .busy(busy), .gen_addr(gen_addr),
    .addr_sel(addr_sel), .comp_clr(comp_clr), .comp_en(comp_en), .ref_en(ref_en),
    .old_xfer(old_xfer), .mem_we(mem_we), .cmp_en(cmp_en)
  );

  int vectors = 0;
  int miscmp  = 0;

  // behavioural model state
  int mmode = M_IDLE, mtest = 0, mcnt = 0;
  // bench-side datapath
  logic [W-1:0]  mem [DEPTH];
  logic [W-1:0]  test_reg = '0;
  logic [W-1:0]  wdata = '0;
  int            sys_addr = 0;
  logic [CW-1:0] acc = '0, refr = '0, last_diff = '0;
  bit            cmp_seen = 0, accepted = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] charw(input int a, input logic [W-1:0] w);
    logic [BW-1:0] bs;
    bs = '0;
    for (int i = 0; i < W; i++) if (w[i]) bs = bs ^ BW'(i);
    return {((^w) ? AW'(a) : AW'(0)), bs};
  endfunction

  function automatic logic [CW-1:0] full_char();
    logic [CW-1:0] s;
    s = '0;
    for (int a = 0; a < DEPTH; a++) s = s ^ charw(a, mem[a]);
    return s;
  endfunction

  task automatic step(input bit i_init, input bit i_bist, input bit i_wv);
    bit e_rdy, s_rdy, s_sel, s_clr, s_en, s_ref, s_x, s_we, s_cmp;
    int e_addr, s_addr, a;
    logic [W-1:0] wd;
    logic [CW-1:0] nx;
    init_req = i_init; run_bist = i_bist; wr_valid = i_wv;
    #1;
    e_rdy  = (mmode == M_IDLE) && !i_init && !i_bist;
    e_addr = (mmode == M_SCAN) ? mcnt : 0;
    chk(comp_clr == (mmode == M_CLR), "R2 comp_clr", comp_clr, mmode == M_CLR);
    chk(gen_addr == AW'(e_addr), "R2 gen_addr", gen_addr, e_addr);
    chk(ref_en == ((mmode == M_SCAN && mcnt == DEPTH-1 && mtest == 0) || mmode == M_WUPD),
        "R3 ref_en", ref_en, (mmode == M_SCAN && mcnt == DEPTH-1 && mtest == 0) || mmode == M_WUPD);
    chk(cmp_en == (mmode == M_CMP), "R4 cmp_en", cmp_en, mmode == M_CMP);
    chk(wr_ready == e_rdy, "R5 wr_ready", wr_ready, e_rdy);
    chk(old_xfer == (mmode == M_WCAP), "R6 old_xfer", old_xfer, mmode == M_WCAP);
    chk(mem_we == (mmode == M_WUPD), "R7 mem_we", mem_we, mmode == M_WUPD);
    chk(comp_en == (mmode == M_SCAN || mmode == M_WUPD), "R7 comp_en", comp_en,
        mmode == M_SCAN || mmode == M_WUPD);
    chk(busy == (mmode >= M_CLR), "R8 busy", busy, mmode >= M_CLR);
    chk(addr_sel == (mmode == M_CLR || mmode == M_SCAN), "R8 addr_sel", addr_sel,
        mmode == M_CLR || mmode == M_SCAN);
    s_rdy = wr_ready; s_sel = addr_sel; s_clr = comp_clr; s_en = comp_en; s_ref = ref_en;
    s_x = old_xfer; s_we = mem_we; s_cmp = cmp_en; s_addr = int'(gen_addr);
    accepted = s_rdy && i_wv;
    @(posedge clk);
    // model
    case (mmode)
      M_IDLE: if (i_init) begin mmode = M_CLR; mtest = 0; end
              else if (i_bist) begin mmode = M_CLR; mtest = 1; end
              else if (i_wv) mmode = M_WCAP;
      M_WCAP: mmode = M_WUPD;
      M_WUPD: mmode = M_IDLE;
      M_CLR:  begin mmode = M_SCAN; mcnt = 0; end
      M_SCAN: if (mcnt == DEPTH-1) begin mmode = mtest ? M_CMP : M_IDLE; mcnt = 0; end
              else mcnt++;
      default: mmode = M_IDLE;
    endcase
    // datapath driven by the observed strobes
    nx = acc;
    if (s_clr) nx = '0;
    else if (s_en) begin
      a  = s_sel ? s_addr : sys_addr;
      wd = s_sel ? mem[s_addr] : (test_reg ^ wdata);
      nx = acc ^ charw(a, wd);
    end
    if (s_ref) refr = nx;
    if (s_cmp) begin cmp_seen = 1; last_diff = nx ^ refr; end
    acc = nx;
    if (s_x) test_reg = mem[sys_addr];
    if (s_we) mem[sys_addr] = wdata;
    @(negedge clk);
  endtask

  task automatic learn();
    step(1, 0, 0);
    repeat (DEPTH + 1) step(0, 0, 0);
  endtask

  task automatic selftest();
    cmp_seen = 0;
    step(0, 1, 0);
    repeat (DEPTH + 2) step(0, 0, 0);
  endtask

  task automatic do_write(input int a, input logic [W-1:0] d);
    int guard;
    sys_addr = a; wdata = d; guard = 0;
    do begin step(0, 0, 1); guard++; end while (!accepted && guard < 100);
    step(0, 0, 0);
    step(0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    miscmp++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = W'((a * 37 + 11) ^ (a << 3));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(!busy && !addr_sel && !comp_clr && !comp_en && !ref_en && !old_xfer && !mem_we &&
        !cmp_en && gen_addr == '0 && wr_ready, "R1 idle after reset",
        {busy, comp_en, ref_en, cmp_en, wr_ready}, 5'b00001);
    @(negedge clk);
    step(0, 0, 0);

    // R2 R3: learn pass
    learn();
    chk(refr == full_char(), "R3 reference after learn", refr, full_char());

    // R4: clean self-test
    selftest();
    chk(cmp_seen && last_diff == '0, "R4 clean compare", last_diff, 0);

    // R6 R7 R10: writes with various patterns, including an unchanged word
    do_write(3, 8'hA5);
    do_write(0, 8'h00);
    do_write(15, 8'hFF);
    do_write(3, 8'hA5);
    do_write(7, 8'h01);
    chk(refr == full_char(), "R10 reference tracks writes", refr, full_char());

    // R7: held valid, accepted every third cycle
    sys_addr = 9; wdata = 8'h3C;
    repeat (7) step(0, 0, 1);
    step(0, 0, 0); step(0, 0, 0);
    chk(refr == full_char(), "R7 back-to-back writes", refr, full_char());

    // R9: init and pending write together; write stalls behind the scan
    sys_addr = 12; wdata = 8'h6E;
    step(1, 0, 1);
    repeat (DEPTH + 1) step(0, 0, 1);
    chk(accepted == 0, "R9 write stalled during learn", accepted, 0);
    step(0, 0, 1);
    chk(accepted == 1, "R9 pending write accepted after scan", accepted, 1);
    step(0, 0, 0); step(0, 0, 0);
    chk(refr == full_char(), "R9 reference after stalled write", refr, full_char());

    // R9: init beats self-test
    cmp_seen = 0;
    step(1, 1, 0);
    repeat (DEPTH + 2) step(0, 0, 0);
    chk(!cmp_seen && refr == full_char(), "R9 learn wins over self-test", cmp_seen, 0);

    // R11: requests during self-test and during a write are ignored
    cmp_seen = 0;
    step(0, 1, 0);
    repeat (DEPTH + 2) step(1, 1, 0);
    chk(cmp_seen && last_diff == '0, "R11 self-test unchanged by requests", last_diff, 0);
    step(0, 0, 0);
    sys_addr = 4; wdata = 8'h99;
    step(0, 0, 1);
    step(1, 1, 0);
    step(0, 1, 0);
    chk(mmode == M_IDLE && refr == full_char(), "R11 write unchanged by requests", refr, full_char());
    step(0, 0, 0);

    // R10: self-test after mixed traffic passes
    selftest();
    chk(cmp_seen && last_diff == '0, "R10 compare after traffic", last_diff, 0);

    // R4: single flipped bit reports its address
    mem[5][3] = ~mem[5][3];
    selftest();
    chk(cmp_seen && last_diff == charw(5, 8'h08), "R4 fault diagnosis", last_diff, charw(5, 8'h08));

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule